// File: doc/BRIEF.md
# Dual-Path Prioritized Interrupt Vector Arbiter

The arbiter collects interrupt events from sixteen maskable levels and three special sources (non-maskable interrupt, unimplemented opcode and software trap). It keeps a pending bit for every source. Whenever it is idle, it picks one winner and presents that winner's vector address to a CPU. Each maskable level can be steered, through a per-level select bit, either to the ordinary vector service or to a peripheral transaction server (PTS) service path. The two paths use separate vector tables. Any eligible PTS-steered level outranks every ordinary maskable level. The special sources outrank both paths and ignore the mask and the global enable.

A two-state machine drives the CPU side. In `ST_IDLE`, the arbiter examines the pending set. If a winner exists, it registers that winner's vector, its path flag and its identity, and then takes the `IDLE->PRESENT` transition. In `ST_PRESENT`, the request output is high and the outputs are frozen. A high `ack` takes the `PRESENT->IDLE` transition and clears only the winner's pending bit. Without `ack`, the `PRESENT->PRESENT` hold transition applies. An idle cycle with no eligible source takes the `IDLE->IDLE` transition.

Top module: `irqv_arbiter`

## Requirements
- R1: After reset, `cpu_req` is 0, `vec_addr` is 0000h, `pts_flag` is 0 and no source is pending.
- R2: An ordinary maskable level n wins with `pts_flag`=0 and a vector of 2000h+2n for n=0..7, or 2030h+2(n-8) for n=8..15.
- R3: A PTS-steered level n (`pts_sel[n]`=1) wins with `pts_flag`=1 and a vector of 2040h+2n for n=0..7, or 2050h+2(n-8) for n=8..15.
- R4: Within one path, the highest-numbered eligible level wins.
- R5: Any eligible PTS-steered level beats every eligible ordinary level, whatever their level numbers.
- R6: The special sources have fixed vectors with `pts_flag`=0: NMI 203Eh, unimplemented opcode 2012h, software trap 2010h. They are served even when `mask` is 0 and `glob_en` is 0.
- R7: Among the special sources, NMI beats unimplemented opcode, and unimplemented opcode beats software trap. All three beat every maskable level.
- R8: A maskable level is eligible only while its pending bit, its `mask` bit and `glob_en` are all 1. A level that is not eligible stays pending and is served once it becomes eligible.
- R9: While `cpu_req` is high and `ack` is low, `vec_addr` and `pts_flag` hold their values, even if a higher-priority source arrives. An `ack` while `cpu_req` is low has no effect.
- R10: An `ack` sampled with `cpu_req` high clears only the winner's pending bit and drops `cpu_req` for one cycle. On the next edge, the remaining sources are arbitrated again.
- R11: An event pulse sampled on one edge raises `cpu_req`, with its vector, after the following edge, provided the arbiter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set | input | 16 | One-cycle event pulses for the maskable levels; bit n is level n |
| nmi_set | input | 1 | Event pulse for the non-maskable interrupt |
| undef_set | input | 1 | Event pulse for the unimplemented-opcode source |
| trap_set | input | 1 | Event pulse for the software trap |
| mask | input | 16 | Per-level enable; bit n is level n |
| pts_sel | input | 16 | Per-level path select; 1 selects the PTS path |
| glob_en | input | 1 | Global enable for the maskable levels |
| ack | input | 1 | CPU acknowledge of the presented vector |
| cpu_req | output | 1 | Request to the CPU; high in ST_PRESENT |
| vec_addr | output | 16 | Vector address of the presented winner |
| pts_flag | output | 1 | 1 when the presented winner uses the PTS path |

## Verification
An event pulse is captured into the pending set on the first edge after it is driven. The vector appears, together with `cpu_req`, after the second edge. An `ack` drops `cpu_req` after the edge that samples it, and the next winner appears one edge later. The bench drives inputs 1 ns after each falling edge and samples on falling edges, so every check falls within these windows. A behavioural reference model, updated on rising edges from the same inputs, is compared with the outputs on every cycle. Directed checks tagged by requirement are made at the exact cycles given above.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NUM_LVL   = 16;
    localparam int NUM_SRC   = NUM_LVL + 3;
    localparam int ID_W      = $clog2(NUM_SRC);
    localparam int ADDR_W    = 16;
    localparam int IDX_NMI   = NUM_LVL;
    localparam int IDX_UNDEF = NUM_LVL + 1;
    localparam int IDX_TRAP  = NUM_LVL + 2;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic            valid;
        logic            pts;
        logic [ID_W-1:0] id;
    } winner_t;

    function automatic logic [ADDR_W-1:0] vector_of(input logic [ID_W-1:0] id, input logic pts);
        logic [ADDR_W-1:0] v;
        if (id == ID_W'(IDX_NMI))        v = 16'h203E;
        else if (id == ID_W'(IDX_UNDEF)) v = 16'h2012;
        else if (id == ID_W'(IDX_TRAP))  v = 16'h2010;
        else if (id < ID_W'(8))          v = (pts ? 16'h2040 : 16'h2000) + ADDR_W'({id, 1'b0});
        else                             v = (pts ? 16'h2050 : 16'h2030) + ADDR_W'({id - ID_W'(8), 1'b0});
        return v;
    endfunction
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending
    import irqv_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)        pend_o[g] <= 1'b0;
                else if (set_i[g]) pend_o[g] <= 1'b1;
                else if (clr_i[g]) pend_o[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irqv_select.sv
module irqv_select
    import irqv_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_LVL-1:0] mask_i,
    input  logic [NUM_LVL-1:0] pts_sel_i,
    input  logic               glob_en_i,
    output winner_t            win_o
);
    logic [NUM_LVL-1:0] elig;
    logic [NUM_LVL-1:0] pts_elig;
    logic [NUM_LVL-1:0] nrm_elig;
    logic               pts_any, nrm_any;
    logic [ID_W-1:0]    pts_top, nrm_top;

    assign elig     = pend_i[NUM_LVL-1:0] & mask_i & {NUM_LVL{glob_en_i}};
    assign pts_elig = elig & pts_sel_i;
    assign nrm_elig = elig & ~pts_sel_i;

    always_comb begin
        pts_any = 1'b0;
        nrm_any = 1'b0;
        pts_top = '0;
        nrm_top = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (pts_elig[i]) begin
                pts_any = 1'b1;
                pts_top = ID_W'(i);
            end
            if (nrm_elig[i]) begin
                nrm_any = 1'b1;
                nrm_top = ID_W'(i);
            end
        end
    end

    always_comb begin
        win_o = '0;
        if (pend_i[IDX_NMI])        win_o = '{valid: 1'b1, pts: 1'b0, id: ID_W'(IDX_NMI)};
        else if (pend_i[IDX_UNDEF]) win_o = '{valid: 1'b1, pts: 1'b0, id: ID_W'(IDX_UNDEF)};
        else if (pend_i[IDX_TRAP])  win_o = '{valid: 1'b1, pts: 1'b0, id: ID_W'(IDX_TRAP)};
        else if (pts_any)           win_o = '{valid: 1'b1, pts: 1'b1, id: pts_top};
        else if (nrm_any)           win_o = '{valid: 1'b1, pts: 1'b0, id: nrm_top};
    end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_set,
    input  logic               nmi_set,
    input  logic               undef_set,
    input  logic               trap_set,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] pts_sel,
    input  logic               glob_en,
    input  logic               ack,
    output logic               cpu_req,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               pts_flag
);
    arb_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [ID_W-1:0]    win_id_q;
    winner_t            win;

    assign set_vec = {trap_set, undef_set, nmi_set, irq_set};
    assign clr_vec = (state_q == ST_PRESENT && ack) ? (NUM_SRC'(1) << win_id_q) : '0;

    irqv_pending #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend_q)
    );

    irqv_select u_sel (
        .pend_i    (pend_q),
        .mask_i    (mask),
        .pts_sel_i (pts_sel),
        .glob_en_i (glob_en),
        .win_o     (win)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (win.valid) state_d = ST_PRESENT;
            ST_PRESENT: if (ack)       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_addr <= '0;
            pts_flag <= 1'b0;
            win_id_q <= '0;
        end else if (state_q == ST_IDLE && win.valid) begin
            vec_addr <= vector_of(win.id, win.pts);
            pts_flag <= win.pts;
            win_id_q <= win.id;
        end
    end

    assign cpu_req = (state_q == ST_PRESENT);
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               ack,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic               pts_flag,
    input logic               glob_en,
    input logic [NUM_LVL-1:0] mask,
    input logic [NUM_LVL-1:0] pts_sel,
    input logic [NUM_SRC-1:0] pend_q
);
    // R9
    hold_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !ack) |=> (cpu_req && $stable(vec_addr) && $stable(pts_flag)));

    // R10
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && ack) |=> !cpu_req);

    // R3
    pts_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && pts_flag) |-> (vec_addr >= 16'h2040 && vec_addr <= 16'h205E));

    // R7
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_req) && $past(pend_q[IDX_NMI])) |-> (vec_addr == 16'h203E && !pts_flag));

    // R5
    pts_beats_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_req) && $past(glob_en) && ($past(pend_q[IDX_TRAP:IDX_NMI]) == '0)
         && ($past(pend_q[NUM_LVL-1:0] & mask & pts_sel) != '0)) |-> pts_flag);

    // R8
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_req) && !$past(glob_en)) |->
        (vec_addr == 16'h203E || vec_addr == 16'h2012 || vec_addr == 16'h2010));
endmodule

bind irqv_arbiter irqv_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .ack      (ack),
    .vec_addr (vec_addr),
    .pts_flag (pts_flag),
    .glob_en  (glob_en),
    .mask     (mask),
    .pts_sel  (pts_sel),
    .pend_q   (pend_q)
);

// File: tb/irqv_arbiter_bench.sv
`timescale 1ns/1ps
module irqv_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_set = '0;
    logic        nmi_set = 1'b0, undef_set = 1'b0, trap_set = 1'b0;
    logic [15:0] mask = '0, pts_sel = '0;
    logic        glob_en = 1'b0, ack = 1'b0;
    logic        cpu_req, pts_flag;
    logic [15:0] vec_addr;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    irqv_arbiter u_irqv_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .nmi_set(nmi_set),
        .undef_set(undef_set), .trap_set(trap_set), .mask(mask),
        .pts_sel(pts_sel), .glob_en(glob_en), .ack(ack),
        .cpu_req(cpu_req), .vec_addr(vec_addr), .pts_flag(pts_flag)
    );

    // behavioural reference: pending as bit list, 16=nmi 17=undef 18=trap
    bit     m_pend [19];
    bit     m_req;
    int     m_vec;
    bit     m_flag;
    int     m_id;

    function automatic int ref_vec(int id, bit pts);
        if (id == 16) return 'h203E;
        if (id == 17) return 'h2012;
        if (id == 18) return 'h2010;
        if (pts) return (id < 8) ? 'h2040 + 2*id : 'h2050 + 2*(id-8);
        return (id < 8) ? 'h2000 + 2*id : 'h2030 + 2*(id-8);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_req = 0; m_vec = 0; m_flag = 0; m_id = 0;
        end else begin
            bit nxt [19];
            int w; bit wp;
            foreach (m_pend[i]) nxt[i] = m_pend[i];
            if (m_req && ack) nxt[m_id] = 0;
            for (int i = 0; i < 16; i++) if (irq_set[i]) nxt[i] = 1;
            if (nmi_set) nxt[16] = 1;
            if (undef_set) nxt[17] = 1;
            if (trap_set) nxt[18] = 1;
            if (m_req) begin
                if (ack) m_req = 0;
            end else begin
                w = -1; wp = 0;
                if (m_pend[16]) w = 16;
                else if (m_pend[17]) w = 17;
                else if (m_pend[18]) w = 18;
                else begin
                    for (int l = 15; l >= 0 && w < 0; l--)
                        if (m_pend[l] && mask[l] && glob_en && pts_sel[l]) begin w = l; wp = 1; end
                    for (int l = 15; l >= 0 && w < 0; l--)
                        if (m_pend[l] && mask[l] && glob_en && !pts_sel[l]) w = l;
                end
                if (w >= 0) begin
                    m_req = 1; m_id = w; m_flag = wp; m_vec = ref_vec(w, wp);
                end
            end
            foreach (m_pend[i]) m_pend[i] = nxt[i];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (cpu_req !== m_req || vec_addr !== 16'(m_vec) || pts_flag !== m_flag) begin
                n_bad++;
                $display("FAIL model cyc %0d: req/vec/flag %b/%h/%b expected %b/%h/%b",
                         cyc, cpu_req, vec_addr, pts_flag, m_req, 16'(m_vec), m_flag);
            end
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic expect_out(bit er, int ev, bit ef, string tag);
        n_cmp++;
        if (cpu_req !== er || (er && (vec_addr !== 16'(ev) || pts_flag !== ef))) begin
            n_bad++;
            $display("FAIL %s: req/vec/flag %b/%h/%b expected %b/%h/%b",
                     tag, cpu_req, vec_addr, pts_flag, er, 16'(ev), ef);
        end
    endtask

    task automatic pulse_irq(logic [15:0] v);
        irq_set = v; tick(); irq_set = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        expect_out(0, 0, 0, "R1 reset");
        n_cmp++;
        if (vec_addr !== 16'h0 || pts_flag !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outs: %h/%b expected 0000/0", vec_addr, pts_flag);
        end
        mask = 16'hFFFF; glob_en = 1'b1;

        // R11 + R2
        pulse_irq(16'h0008);
        expect_out(0, 0, 0, "R11 not yet");
        tick();
        expect_out(1, 'h2006, 0, "R11 R2 level3");
        do_ack();
        expect_out(0, 0, 0, "R10 drop");
        pulse_irq(16'h1000); tick();
        expect_out(1, 'h2038, 0, "R2 level12");
        do_ack();

        // R3
        pts_sel = 16'h0220;
        pulse_irq(16'h0020); tick();
        expect_out(1, 'h204A, 1, "R3 level5");
        do_ack();
        pulse_irq(16'h0200); tick();
        expect_out(1, 'h2052, 1, "R3 level9");
        do_ack();

        // R5 then R10
        pts_sel = 16'h0004;
        pulse_irq(16'h4004); tick();
        expect_out(1, 'h2044, 1, "R5 pts2 over normal14");
        do_ack();
        expect_out(0, 0, 0, "R10 gap");
        tick();
        expect_out(1, 'h203C, 0, "R10 rearbitrate level14");
        do_ack();

        // R4
        pts_sel = 16'h0082;
        pulse_irq(16'h0810); tick();
        expect_out(1, 'h2036, 0, "R4 normal 11 over 4");
        do_ack(); tick();
        expect_out(1, 'h2008, 0, "R4 then level4");
        do_ack();
        pulse_irq(16'h0082); tick();
        expect_out(1, 'h204E, 1, "R4 pts 7 over 1");
        do_ack(); tick();
        expect_out(1, 'h2042, 1, "R4 then pts1");
        do_ack();
        pts_sel = '0;

        // R8 masking and enable
        mask = 16'hFFBF;
        pulse_irq(16'h0040); tick(); tick();
        expect_out(0, 0, 0, "R8 masked");
        mask = 16'hFFFF; glob_en = 1'b0; tick(); tick();
        expect_out(0, 0, 0, "R8 global off");
        // R9 ack while idle does not clear pending
        do_ack(); tick();
        expect_out(0, 0, 0, "R9 idle ack no req");
        glob_en = 1'b1; tick();
        expect_out(1, 'h200C, 0, "R8 R9 served after enable");
        // R9 hold against higher priority arrival
        nmi_set = 1'b1; tick(); nmi_set = 1'b0; tick(); tick();
        expect_out(1, 'h200C, 0, "R9 held");
        do_ack(); tick();
        expect_out(1, 'h203E, 0, "R7 nmi next");
        do_ack();

        // R6 specials bypass gating
        mask = '0; glob_en = 1'b0;
        nmi_set = 1'b1; tick(); nmi_set = 1'b0; tick();
        expect_out(1, 'h203E, 0, "R6 nmi gated off");
        do_ack();
        undef_set = 1'b1; trap_set = 1'b1; tick(); undef_set = 1'b0; trap_set = 1'b0; tick();
        expect_out(1, 'h2012, 0, "R7 undef over trap");
        do_ack(); tick();
        expect_out(1, 'h2010, 0, "R6 trap");
        do_ack();
        mask = 16'hFFFF; glob_en = 1'b1; pts_sel = 16'h8000;
        irq_set = 16'h8000; trap_set = 1'b1; tick(); irq_set = '0; trap_set = 1'b0; tick();
        expect_out(1, 'h2010, 0, "R7 trap over pts15");
        do_ack(); tick();
        expect_out(1, 'h205E, 1, "R3 pts15");
        do_ack(); tick(); tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run ended expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule